// File: doc/BRIEF.md
# Reset and Interrupt Entry Sequencer

This block is the control sequencer that brings a small 8-bit accumulator processor with 16-bit addresses out of reset and into a maskable interrupt handler. It owns the memory port while it works. It reads the register file through plain read ports and updates the program counter, the stack pointer and the flags through load strobes. Instruction decode lies outside the block. The decoder raises `start_boundary` for one cycle between instructions, and the sequencer may take an interrupt only in that cycle.

When reset is released, the block sets the interrupt mask in the flags. It then reads a two-byte start vector at the top of memory and loads it into the program counter, high byte first. When a request is accepted, the block pushes the whole register file onto a descending stack, one byte per clock. It then lowers the stack pointer by seven, sets the mask and loads the program counter from the interrupt vector. A free-running cycle counter clears at reset. `busy` is high for the whole of an entry, and `done` marks its last cycle.

The memory port has a fixed latency and no back-pressure. A read issued in one cycle returns `mem_rdata` in the next cycle. A write completes in the cycle it is issued. The register-file load strobes are single-cycle pulses with no handshake.

Top module: `vec_seq_top`

## Requirements
- R1: While `rst_n` is low, `cyc_count` is 0. After release it increases by exactly 1 per clock. The reset sequence sets flags bit 4 (the interrupt mask) and bits 7 and 6 to 1, and keeps the other flag bits.
- R2: After reset the block reads address 0xFFFE and then address 0xFFFF, one read per cycle. It loads the program counter with the byte from 0xFFFE as the high byte and the byte from 0xFFFF as the low byte, and it pulses `done` once.
- R3: A request is never accepted while flags bit 4 is 1. `busy` stays low.
- R4: A request is accepted only in a cycle where `start_boundary` is high and the block is idle. An `irq` pulse that arrives while the block is busy, or outside a boundary, is latched and held until it is accepted.
- R5: On entry the block writes seven bytes to the addresses SP, SP-1, …, SP-6, where SP is the stack pointer at acceptance. The bytes go in this order: PC low, PC high, index low, index high, A, B, flags.
- R6: After entry the stack pointer equals its value at acceptance minus 7, modulo 2^16.
- R7: The flags byte that is pushed is the value at acceptance. After entry, flags bit 4 is 1 and bits 7 and 6 are 1. The other flag bits are unchanged.
- R8: After the pushes the block reads 0xFFF8 and then 0xFFF9. The program counter becomes {byte at 0xFFF8, byte at 0xFFF9}.
- R9: `busy` is high for exactly 10 cycles, starting in the cycle after acceptance. `done` is high only in the 10th of these cycles. No cycle has both a read and a write.
- R10: The pushed program counter equals the program counter at acceptance; it is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq | input | 1 | Maskable interrupt request |
| start_boundary | input | 1 | High for one cycle at an instruction boundary |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| x_in | input | 16 | Current index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Flags register |
| pc_ld | output | 1 | Program counter load strobe |
| pc_ld_val | output | 16 | Program counter load value |
| sp_ld | output | 1 | Stack pointer load strobe |
| sp_ld_val | output | 16 | Stack pointer load value |
| ccr_ld | output | 1 | Flags load strobe |
| ccr_ld_val | output | 8 | Flags load value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| cyc_count | output | 32 | Cycles since reset |

## Verification
The bench sweeps a range of register-file contents and memory patterns. One of the stack pointers is 0x0003, so the pushes wrap through address 0. A design that subtracted the offset in the wrong width, or used wrapping arithmetic incorrectly, would write to the wrong addresses or leave the wrong final stack pointer. A masked request is held and is then accepted once the mask clears. A second `irq` pulse during an entry must survive until a later boundary. A block that dropped requests, or sampled outside a boundary, would show the wrong `busy` timing. The bench also checks the push byte order, which vector byte is taken as the high byte, and the cycle in which `done` rises. Any of these would catch a swapped lane, a reversed endian order or a sequence that is one step too long.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH,
    S_VHI,
    S_VLO,
    S_LOAD
  } seq_state_t;

  localparam int unsigned SAVE_BYTES = 7;
endpackage

// File: rtl/vecseq_tally.sv
module vecseq_tally #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/vecseq_irq_gate.sv
module vecseq_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic start_boundary,
  input  logic idle,
  input  logic masked,
  output logic accept
);
  logic pend;
  logic want;

  assign want   = pend | irq;
  assign accept = start_boundary & idle & want & ~masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= want & ~accept;
  end
endmodule

// File: rtl/vecseq_save_mux.sv
module vecseq_save_mux #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 3
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] x,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] f,
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] byte_o
);
  localparam int unsigned TOTW = 2*AW + 3*DW;
  localparam int unsigned NB   = TOTW / DW;

  logic [TOTW-1:0] save_vec;
  logic [DW-1:0]   lane [NB];

  // Lane 0 is the first byte pushed.
  assign save_vec = {f, b, a, x, pc};

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = save_vec[g*DW +: DW];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NB; k++)
      if (idx == IW'(k)) byte_o = lane[k];
  end
endmodule

// File: rtl/vec_seq_top.sv
module vec_seq_top
  import vecseq_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned CW       = 32,
  parameter int unsigned MASK_BIT = 4,
  parameter logic [15:0] RST_VEC  = 16'hFFFE,
  parameter logic [15:0] IRQ_VEC  = 16'hFFF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic          start_boundary,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] x_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] ccr_in,
  output logic          pc_ld,
  output logic [AW-1:0] pc_ld_val,
  output logic          sp_ld,
  output logic [AW-1:0] sp_ld_val,
  output logic          ccr_ld,
  output logic [DW-1:0] ccr_ld_val,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cyc_count
);
  localparam int unsigned IW = $clog2(SAVE_BYTES);
  localparam logic [IW-1:0] LAST_IDX = IW'(SAVE_BYTES - 1);
  localparam logic [DW-1:0] SET_BITS = DW'((1 << MASK_BIT) | (3 << (DW - 2)));

  seq_state_t    state;
  logic [IW-1:0] idx;
  logic [AW-1:0] vec;
  logic          from_irq;
  logic [DW-1:0] hi_byte;
  logic [AW-1:0] pc_s, sp_s, x_s;
  logic [DW-1:0] a_s, b_s, f_s;
  logic          accept;
  logic [DW-1:0] push_byte;

  vecseq_tally #(.CW(CW)) u_tally (
    .clk(clk), .rst_n(rst_n), .count(cyc_count)
  );

  vecseq_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .irq(irq), .start_boundary(start_boundary),
    .idle(state == S_IDLE), .masked(ccr_in[MASK_BIT]), .accept(accept)
  );

  vecseq_save_mux #(.AW(AW), .DW(DW), .IW(IW)) u_mux (
    .pc(pc_s), .x(x_s), .a(a_s), .b(b_s), .f(f_s), .idx(idx), .byte_o(push_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_VHI;
      vec      <= AW'(RST_VEC);
      from_irq <= 1'b0;
      idx      <= '0;
      hi_byte  <= '0;
      pc_s     <= '0;
      sp_s     <= '0;
      x_s      <= '0;
      a_s      <= '0;
      b_s      <= '0;
      f_s      <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          pc_s     <= pc_in;
          sp_s     <= sp_in;
          x_s      <= x_in;
          a_s      <= a_in;
          b_s      <= b_in;
          f_s      <= ccr_in;
          idx      <= '0;
          vec      <= AW'(IRQ_VEC);
          from_irq <= 1'b1;
          state    <= S_PUSH;
        end
        S_PUSH: begin
          if (idx == LAST_IDX) state <= S_VHI;
          else                 idx   <= idx + 1'b1;
        end
        S_VHI: state <= S_VLO;
        S_VLO: begin
          hi_byte <= mem_rdata;
          state   <= S_LOAD;
        end
        S_LOAD: begin
          from_irq <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = (state == S_VHI) || (state == S_VLO);
    mem_wr   = (state == S_PUSH);
    mem_addr = '0;
    case (state)
      S_PUSH:  mem_addr = sp_s - AW'(idx);
      S_VHI:   mem_addr = vec;
      S_VLO:   mem_addr = vec + 1'b1;
      default: mem_addr = '0;
    endcase
  end

  assign mem_wdata  = mem_wr ? push_byte : '0;
  assign sp_ld      = (state == S_VHI) && from_irq;
  assign sp_ld_val  = sp_s - AW'(SAVE_BYTES);
  assign ccr_ld     = (state == S_VHI);
  assign ccr_ld_val = ccr_in | SET_BITS;
  assign pc_ld      = (state == S_LOAD);
  assign pc_ld_val  = {hi_byte, mem_rdata};
  assign done       = (state == S_LOAD);
  assign busy       = (state != S_IDLE);
endmodule

// File: rtl/vec_seq_chk.sv
module vec_seq_chk #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 8,
  parameter int unsigned MASK_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          ccr_ld,
  input logic [DW-1:0] ccr_ld_val,
  input logic          pc_ld
);
  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - 1'b1));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_ld |-> ccr_ld_val[MASK_BIT]);

  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8
  pc_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |-> $past(mem_rd));

  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind vec_seq_top vec_seq_chk #(.AW(AW), .DW(DW), .MASK_BIT(MASK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .busy(busy), .done(done), .ccr_ld(ccr_ld),
  .ccr_ld_val(ccr_ld_val), .pc_ld(pc_ld)
);

// File: tb/sim_vec_seq_top.sv
module sim_vec_seq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic start_boundary = 1'b0;
  logic mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] pc_r = 16'h0, sp_r = 16'h0, x_r = 16'h0;
  logic [7:0]  a_r = 8'h0, b_r = 8'h0, ccr_r = 8'h00;
  logic pc_ld, sp_ld, ccr_ld, busy, done;
  logic [15:0] pc_ld_val, sp_ld_val;
  logic [7:0]  ccr_ld_val;
  logic [31:0] cyc_count;

  logic [7:0]  seed = 8'h3C;
  logic [15:0] wa [16];
  logic [7:0]  wd [16];
  logic [15:0] ra [8];
  int wcnt = 0, rcnt = 0;
  int n_tests = 0, n_fail = 0;
  int ticks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .start_boundary(start_boundary),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_in(pc_r), .sp_in(sp_r), .x_in(x_r), .a_in(a_r), .b_in(b_r),
    .ccr_in(ccr_r), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val), .sp_ld(sp_ld),
    .sp_ld_val(sp_ld_val), .ccr_ld(ccr_ld), .ccr_ld_val(ccr_ld_val),
    .busy(busy), .done(done), .cyc_count(cyc_count)
  );

  // Memory and register-file models
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_addr[7:0] ^ seed;
      if (rcnt < 8) begin ra[rcnt] <= mem_addr; rcnt <= rcnt + 1; end
    end
    if (mem_wr && wcnt < 16) begin
      wa[wcnt] <= mem_addr; wd[wcnt] <= mem_wdata; wcnt <= wcnt + 1;
    end
    if (pc_ld)  pc_r  <= pc_ld_val;
    if (sp_ld)  sp_r  <= sp_ld_val;
    if (ccr_ld) ccr_r <= ccr_ld_val;
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete (act %0d exp <100000)", ticks);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // Run one entry: optionally raise irq with a boundary, optionally pulse irq mid-way.
  task automatic run_entry(input bit raise_irq, input bit mid_irq, input string tag);
    logic [15:0] pc0, sp0, x0;
    logic [7:0]  a0, b0, f0;
    logic [7:0]  expb [7];
    int bcnt, dcnt, dpos;
    pc0 = pc_r; sp0 = sp_r; x0 = x_r; a0 = a_r; b0 = b_r; f0 = ccr_r;
    expb[0] = pc0[7:0]; expb[1] = pc0[15:8]; expb[2] = x0[7:0];
    expb[3] = x0[15:8]; expb[4] = a0; expb[5] = b0; expb[6] = f0;
    wcnt = 0; rcnt = 0;
    bcnt = 0; dcnt = 0; dpos = 0;
    irq = raise_irq; start_boundary = 1'b1;
    @(negedge clk);
    irq = 1'b0; start_boundary = 1'b0;
    for (int i = 0; i < 14; i++) begin
      if (busy) bcnt++;
      if (done) begin dcnt++; dpos = bcnt; end
      if (mid_irq) irq = (i == 3);
      @(negedge clk);
    end
    irq = 1'b0;
    chk(bcnt == 10, {"R9 busy length ", tag}, bcnt, 10);
    chk(dcnt == 1 && dpos == 10, {"R9 done position ", tag}, dpos, 10);
    chk(wcnt == 7, {"R5 write count ", tag}, wcnt, 7);
    for (int k = 0; k < 7; k++) begin
      chk(wa[k] == sp0 - 16'(k), {"R5 push address ", tag}, wa[k], sp0 - 16'(k));
      chk(wd[k] == expb[k], {"R5 push byte ", tag}, wd[k], expb[k]);
    end
    chk({wd[1], wd[0]} == pc0, {"R10 saved pc ", tag}, {wd[1], wd[0]}, pc0);
    chk(sp_r == sp0 - 16'd7, {"R6 final sp ", tag}, sp_r, sp0 - 16'd7);
    chk(ccr_r == (f0 | 8'hD0), {"R7 flags after ", tag}, ccr_r, f0 | 8'hD0);
    chk(ra[0] == 16'hFFF8 && ra[1] == 16'hFFF9 && rcnt == 2,
        {"R8 vector reads ", tag}, {ra[0], ra[1]}, 32'hFFF8FFF9);
    chk(pc_r == {8'hF8 ^ seed, 8'hF9 ^ seed}, {"R8 new pc ", tag}, pc_r,
        {8'hF8 ^ seed, 8'hF9 ^ seed});
  endtask

  initial begin
    logic [31:0] c1;
    int dseen;
    // Reset phase
    repeat (3) @(negedge clk);
    chk(cyc_count == 0, "R1 count held at 0 in reset", cyc_count, 0);
    ccr_r = 8'h05; rcnt = 0;
    rst_n = 1'b1;
    dseen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) dseen++;
    end
    chk(dseen == 1, "R2 reset done pulses once", dseen, 1);
    chk(pc_r == {8'hFE ^ seed, 8'hFF ^ seed}, "R2 reset pc", pc_r,
        {8'hFE ^ seed, 8'hFF ^ seed});
    chk(rcnt == 2 && ra[0] == 16'hFFFE && ra[1] == 16'hFFFF, "R2 reset read order",
        {ra[0], ra[1]}, 32'hFFFEFFFF);
    chk(ccr_r == 8'hD5, "R1 reset flags", ccr_r, 8'hD5);
    chk(busy == 1'b0, "R1 idle after reset", busy, 0);
    c1 = cyc_count;
    repeat (5) @(negedge clk);
    chk(cyc_count == c1 + 5, "R1 count increments", cyc_count, c1 + 5);

    // Sweep of register-file contents
    for (int t = 0; t < 12; t++) begin
      seed = 8'(t * 37 + 1);
      sp_r = (t == 0) ? 16'h0003 : 16'(t * 16'h1357 + 16'h0100);
      pc_r = 16'(t * 16'h2468) ^ 16'h1111;
      x_r  = ~pc_r ^ 16'(t);
      a_r  = 8'(t * 7 + 3);
      b_r  = ~8'(t * 5);
      ccr_r = 8'hC0 | (8'(t) & 8'h2F);
      run_entry(1'b1, 1'b0, "sweep");
    end

    // Masked request is ignored while the mask is set, then held
    ccr_r = 8'hD3; seed = 8'h99;
    irq = 1'b1; start_boundary = 1'b1;
    @(negedge clk);
    irq = 1'b0; start_boundary = 1'b0;
    dseen = 0;
    for (int i = 0; i < 5; i++) begin
      if (busy || mem_wr) dseen++;
      @(negedge clk);
    end
    chk(dseen == 0, "R3 masked request not taken", dseen, 0);
    ccr_r = 8'hC3;
    dseen = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy) dseen++;
      @(negedge clk);
    end
    chk(dseen == 0, "R4 no entry without boundary", dseen, 0);
    sp_r = 16'h8000; pc_r = 16'hBEEF; x_r = 16'h1234; a_r = 8'hA5; b_r = 8'h5A;
    run_entry(1'b0, 1'b1, "held masked request");

    // Pulse seen during busy must still be pending
    ccr_r = 8'hC1;
    dseen = 0;
    for (int i = 0; i < 3; i++) begin
      if (busy) dseen++;
      @(negedge clk);
    end
    chk(dseen == 0, "R4 pending waits for boundary", dseen, 0);
    seed = 8'h42;
    run_entry(1'b0, 1'b0, "held busy-time request");

    // Nothing pending now: a bare boundary starts nothing
    ccr_r = 8'hC0;
    start_boundary = 1'b1;
    @(negedge clk);
    start_boundary = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R4 boundary with no request", busy, 0);

    summary_and_end();
  end
endmodule